// File: doc/BRIEF.md
# Command/Response Transfer Controller

This block steps each locality of a secure-module host interface through the life of one command: a host streams a command into a shared byte buffer through a data port of 1 to 4 bytes per access, starts it, waits for the command processor to finish, and then drains the response through the same port. The block tracks a five-state machine per locality. It holds a single read/write offset into the shared buffer. It keeps the transfer status flags, and it works out a burst count that tells the host how many bytes it may move next.

An external arbiter supplies the active locality. Status and data accesses from any other locality are ignored. Status writes arrive already decoded into three one-hot commands: command-ready, go and response-retry. The command length is taken from a big-endian header field once enough bytes are present. The command processor reads the buffer, writes its response back into it, and signals completion. Interrupt requests leave as one-cycle pulses tagged with a locality, for a separate interrupt block to mask and latch.

Top module: `cmd_rsp_xfer`

## Requirements
- R1: After reset every locality is idle, the offset is zero, and `sts_o` shows only the family field. `sts_o` encoding: bit0 valid, bit1 data-available, bit2 expect, bit3 command-ready, bit4 self-test-done, bit5 zero, bits 7:6 the FAMILY parameter.
- R2: The `sts_val_i` encoding is bit0 command-ready, bit1 go and bit2 retry; any value that is not exactly one of these does nothing. Command-ready in idle enters ready, sets command-ready and pulses `irq_cmd_rdy_o`. In ready it only zeroes the offset.
- R3: The first data write in ready enters reception and sets expect and valid. Data writes in idle, execution or completion are dropped. Bytes go into the buffer low byte of `dat_wdata_i` first.
- R4: Once the offset exceeds 5 while expect is set, the length in buffer bytes 2..5 (big-endian) is compared with the offset. Expect stays set while the length is larger and clears otherwise. `irq_sts_vld_o` pulses only if valid was clear before.
- R5: Go is accepted only in reception with expect clear. It enters execution and pulses `be_go_o` with `be_len_o` equal to the offset.
- R6: On `be_done_i` with no abort pending, the executing locality enters completion with valid and data-available set and the offset zeroed. `irq_data_av_o` and `irq_sts_vld_o` pulse.
- R7: A data read returns response bytes in buffer order, one per requested byte, only in completion while data-available is set; every other byte reads 0xFF. Reading the last byte (response length = min(header length, DEPTH)) leaves only valid set and pulses `irq_sts_vld_o`.
- R8: Retry in completion zeroes the offset and sets valid and data-available again.
- R9: Command-ready in completion zeroes the offset, enters ready and clears data-available. If command-ready was not already set, it also sets command-ready and pulses `irq_cmd_rdy_o`.
- R10: Command-ready in reception aborts at once: ready, command-ready set, offset zero, `irq_cmd_rdy_o`. In execution it pulses `be_cancel_o`, and the following completion returns the locality to ready with command-ready set and `irq_cmd_rdy_o` instead of the response flags.
- R11: `burst_o` for the active locality is the remaining response bytes while data-available is set, and otherwise DEPTH minus the offset. It is clamped to 255 when `sts_rd_byte_i` is high, and it is zero for an inactive locality.
- R12: Status and data accesses from a locality that is not active change nothing. Self-test-done is set in every locality by a completion with `be_selftest_i` and survives all later status updates.
- R13: A write that would pass the end of the buffer stores the bytes that fit, drops the rest, and clears expect while leaving valid set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_vld_i | input | 1 | A locality is active |
| act_loc_i | input | LW | Active locality from the arbiter |
| loc_i | input | LW | Locality of the current host access |
| sts_wr_i | input | 1 | Status write strobe |
| sts_val_i | input | 3 | Decoded status command (one-hot) |
| dat_wr_i | input | 1 | Data port write strobe |
| dat_rd_i | input | 1 | Data port read strobe |
| dat_size_i | input | 3 | Access size in bytes, 1 to 4 |
| dat_wdata_i | input | 32 | Write data, first byte in bits 7:0 |
| dat_rdata_o | output | 32 | Read data for the current access |
| sts_rd_byte_i | input | 1 | Status read is one byte wide |
| sts_o | output | 8 | Status flags of locality `loc_i` |
| burst_o | output | OW | Burst count of locality `loc_i` |
| be_go_o | output | 1 | Command start pulse to the backend |
| be_len_o | output | OW | Command length in bytes |
| be_cancel_o | output | 1 | Cancel request pulse |
| be_we_i | input | 1 | Backend buffer write |
| be_idx_i | input | OW | Backend buffer byte index |
| be_byte_i | input | 8 | Backend buffer write byte |
| be_done_i | input | 1 | Backend completion |
| be_selftest_i | input | 1 | Completed command finished self-test |
| irq_cmd_rdy_o | output | 1 | Command-ready interrupt request pulse |
| irq_sts_vld_o | output | 1 | Status-valid interrupt request pulse |
| irq_data_av_o | output | 1 | Data-available interrupt request pulse |
| irq_loc_o | output | LW | Locality of the interrupt request |

## Verification
A state register left in the wrong place shows up on `sts_o` and `burst_o` in the cycle right after the access that caused it. Examples are expect not clearing once the length field is met, or data-available surviving a command-ready. The offset has no port of its own, but every slip in it changes the burst count at once and changes the read bytes on the next drain. A mistaken abort or completion path is seen one cycle after the strobe, on the interrupt pulses, and later as a wrong status word.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READY,
    ST_RECV,
    ST_EXEC,
    ST_DONE
  } xfer_st_e;

  typedef struct packed {
    logic selftest;
    logic cmd_rdy;
    logic data_av;
    logic expt;
    logic valid;
  } xfer_fl_t;

  localparam logic [2:0] SW_CMD_RDY = 3'b001;
  localparam logic [2:0] SW_GO      = 3'b010;
  localparam logic [2:0] SW_RETRY   = 3'b100;

  // overwrite transfer flags, self-test bit survives
  function automatic xfer_fl_t fl_set(xfer_fl_t f, logic cr, logic da, logic ex, logic v);
    xfer_fl_t r;
    r          = f;
    r.cmd_rdy  = cr;
    r.data_av  = da;
    r.expt     = ex;
    r.valid    = v;
    return r;
  endfunction

endpackage

// File: rtl/ccr_buf.sv
module ccr_buf #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int OW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    hw_mask_i,
  input  logic [OW-1:0] hw_base_i,
  input  logic [31:0]   hw_data_i,
  input  logic          be_we_i,
  input  logic [OW-1:0] be_idx_i,
  input  logic [7:0]    be_byte_i,
  output logic [31:0]   rd_word_o,
  output logic [31:0]   hdr_o,
  output logic [31:0]   hdr_nxt_o
);

  logic [7:0]    mem_q [DEPTH];
  logic [OW-1:0] lane_a [4];
  logic [7:0]    hdr_b [4];
  logic [7:0]    hdr_n [4];

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign lane_a[k] = hw_base_i + OW'(k);
    assign rd_word_o[8*k +: 8] = (int'(lane_a[k]) < DEPTH) ? mem_q[lane_a[k][AW-1:0]] : 8'h00;
  end

  // header bytes 2..5, with forwarding of this cycle's host write
  for (genvar j = 0; j < 4; j++) begin : g_hdr
    assign hdr_b[j] = mem_q[j+2];
    always_comb begin
      hdr_n[j] = hdr_b[j];
      for (int k = 0; k < 4; k++)
        if (hw_mask_i[k] && int'(lane_a[k]) == j + 2) hdr_n[j] = hw_data_i[8*k +: 8];
    end
  end

  assign hdr_o     = {hdr_b[0], hdr_b[1], hdr_b[2], hdr_b[3]};
  assign hdr_nxt_o = {hdr_n[0], hdr_n[1], hdr_n[2], hdr_n[3]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int k = 0; k < 4; k++)
        if (hw_mask_i[k]) mem_q[lane_a[k][AW-1:0]] <= hw_data_i[8*k +: 8];
      if (be_we_i && int'(be_idx_i) < DEPTH) mem_q[be_idx_i[AW-1:0]] <= be_byte_i;
    end
  end

endmodule

// File: rtl/ccr_burst.sv
module ccr_burst #(
  parameter int DEPTH = 64,
  parameter int OW    = $clog2(DEPTH + 1)
) (
  input  logic          hit_i,
  input  logic          data_av_i,
  input  logic [OW-1:0] rsp_len_i,
  input  logic [OW-1:0] off_i,
  input  logic          byte_rd_i,
  output logic [OW-1:0] burst_o
);

  logic [OW-1:0] raw;

  always_comb begin
    if (data_av_i) raw = (rsp_len_i > off_i) ? rsp_len_i - off_i : '0;
    else           raw = OW'(DEPTH) - off_i;
    if (!hit_i)                             burst_o = '0;
    else if (byte_rd_i && int'(raw) > 255)  burst_o = OW'(255);
    else                                    burst_o = raw;
  end

endmodule

// File: rtl/cmd_rsp_xfer.sv
module cmd_rsp_xfer
  import ccr_pkg::*;
#(
  parameter int         NLOC   = 5,
  parameter int         DEPTH  = 64,
  parameter logic [1:0] FAMILY = 2'b01,
  localparam int        LW     = $clog2(NLOC),
  localparam int        OW     = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_vld_i,
  input  logic [LW-1:0] act_loc_i,
  input  logic [LW-1:0] loc_i,
  input  logic          sts_wr_i,
  input  logic [2:0]    sts_val_i,
  input  logic          dat_wr_i,
  input  logic          dat_rd_i,
  input  logic [2:0]    dat_size_i,
  input  logic [31:0]   dat_wdata_i,
  output logic [31:0]   dat_rdata_o,
  input  logic          sts_rd_byte_i,
  output logic [7:0]    sts_o,
  output logic [OW-1:0] burst_o,
  output logic          be_go_o,
  output logic [OW-1:0] be_len_o,
  output logic          be_cancel_o,
  input  logic          be_we_i,
  input  logic [OW-1:0] be_idx_i,
  input  logic [7:0]    be_byte_i,
  input  logic          be_done_i,
  input  logic          be_selftest_i,
  output logic          irq_cmd_rdy_o,
  output logic          irq_sts_vld_o,
  output logic          irq_data_av_o,
  output logic [LW-1:0] irq_loc_o
);

  xfer_st_e      st_q [NLOC];
  xfer_st_e      st_d [NLOC];
  xfer_fl_t      fl_q [NLOC];
  xfer_fl_t      fl_d [NLOC];
  logic [OW-1:0] off_q, off_d;
  logic          abt_q, abt_d;
  logic [LW-1:0] exl_q, exl_d;
  logic          cr_d, sv_d, da_d, go_d, can_d;
  logic [LW-1:0] iloc_d;

  logic          loc_ok, hit;
  logic [LW-1:0] lsel;
  logic [2:0]    sz;
  logic [3:0]    wr_mask;
  logic          wr_open;
  logic [31:0]   rd_word, hdr, hdr_nxt;
  logic [OW-1:0] rsp_len;
  logic [31:0]   rdata;

  assign loc_ok = int'(loc_i) < NLOC;
  assign lsel   = loc_ok ? loc_i : '0;
  assign hit    = loc_ok && act_vld_i && (act_loc_i == loc_i);
  assign sz     = (dat_size_i > 3'd4) ? 3'd4 : dat_size_i;

  assign wr_open = !be_done_i && hit && !sts_wr_i && dat_wr_i &&
                   (st_q[lsel] == ST_READY || (st_q[lsel] == ST_RECV && fl_q[lsel].expt));

  always_comb begin
    for (int k = 0; k < 4; k++)
      wr_mask[k] = wr_open && (3'(k) < sz) && (int'(off_q) + k < DEPTH);
  end

  ccr_buf #(.DEPTH(DEPTH), .OW(OW)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_mask_i (wr_mask),
    .hw_base_i (off_q),
    .hw_data_i (dat_wdata_i),
    .be_we_i   (be_we_i),
    .be_idx_i  (be_idx_i),
    .be_byte_i (be_byte_i),
    .rd_word_o (rd_word),
    .hdr_o     (hdr),
    .hdr_nxt_o (hdr_nxt)
  );

  assign rsp_len = (hdr > 32'(DEPTH)) ? OW'(DEPTH) : hdr[OW-1:0];

  ccr_burst #(.DEPTH(DEPTH), .OW(OW)) u_burst (
    .hit_i     (hit),
    .data_av_i (fl_q[lsel].data_av),
    .rsp_len_i (rsp_len),
    .off_i     (off_q),
    .byte_rd_i (sts_rd_byte_i),
    .burst_o   (burst_o)
  );

  always_comb begin
    xfer_st_e      cur;
    xfer_fl_t      cf, nf;
    logic          vb;
    logic [OW-1:0] o;
    logic [2:0]    nwr;
    st_d   = st_q;
    fl_d   = fl_q;
    off_d  = off_q;
    abt_d  = abt_q;
    exl_d  = exl_q;
    cr_d   = 1'b0;
    sv_d   = 1'b0;
    da_d   = 1'b0;
    go_d   = 1'b0;
    can_d  = 1'b0;
    iloc_d = lsel;
    rdata  = '1;
    cur    = st_q[lsel];
    cf     = fl_q[lsel];
    nf     = cf;
    vb     = 1'b0;
    o      = off_q;
    nwr    = 3'(unsigned'($countones(wr_mask)));
    if (be_done_i && st_q[exl_q] == ST_EXEC) begin
      iloc_d = exl_q;
      off_d  = '0;
      abt_d  = 1'b0;
      if (be_selftest_i)
        for (int i = 0; i < NLOC; i++) fl_d[i].selftest = 1'b1;
      if (abt_q) begin
        st_d[exl_q] = ST_READY;
        fl_d[exl_q] = fl_set(fl_d[exl_q], 1'b1, 1'b0, 1'b0, 1'b0);
        cr_d        = 1'b1;
      end else begin
        st_d[exl_q] = ST_DONE;
        fl_d[exl_q] = fl_set(fl_d[exl_q], 1'b0, 1'b1, 1'b0, 1'b1);
        da_d        = 1'b1;
        sv_d        = 1'b1;
      end
    end else if (hit && sts_wr_i) begin
      case (sts_val_i)
        SW_CMD_RDY: begin
          case (cur)
            ST_IDLE: begin
              st_d[lsel] = ST_READY;
              fl_d[lsel] = fl_set(cf, 1'b1, 1'b0, 1'b0, 1'b0);
              cr_d       = 1'b1;
            end
            ST_READY: off_d = '0;
            ST_RECV: begin
              off_d      = '0;
              st_d[lsel] = ST_READY;
              fl_d[lsel] = fl_set(cf, 1'b1, 1'b0, 1'b0, 1'b0);
              cr_d       = 1'b1;
            end
            ST_EXEC: begin
              abt_d = 1'b1;
              can_d = 1'b1;
            end
            default: begin
              off_d      = '0;
              st_d[lsel] = ST_READY;
              if (!cf.cmd_rdy) begin
                nf   = fl_set(cf, 1'b1, 1'b0, 1'b0, 1'b0);
                cr_d = 1'b1;
              end
              nf.data_av = 1'b0;
              fl_d[lsel] = nf;
            end
          endcase
        end
        SW_GO: begin
          if (cur == ST_RECV && !cf.expt) begin
            st_d[lsel] = ST_EXEC;
            exl_d      = lsel;
            go_d       = 1'b1;
          end
        end
        SW_RETRY: begin
          if (cur == ST_DONE) begin
            off_d      = '0;
            fl_d[lsel] = fl_set(cf, 1'b0, 1'b1, 1'b0, 1'b1);
          end
        end
        default: ;
      endcase
    end else if (hit && dat_wr_i) begin
      if (cur == ST_READY || cur == ST_RECV) begin
        if (cur == ST_READY) begin
          st_d[lsel] = ST_RECV;
          nf         = fl_set(cf, 1'b0, 1'b0, 1'b1, 1'b1);
        end
        vb = nf.valid;
        if (nf.expt) begin
          o = off_q + OW'(nwr);
          if (nwr < sz) begin
            nf = fl_set(nf, 1'b0, 1'b0, 1'b0, 1'b1);
          end else if (int'(o) > 5) begin
            if (hdr_nxt > 32'(o)) nf = fl_set(nf, 1'b0, 1'b0, 1'b1, 1'b1);
            else                  nf = fl_set(nf, 1'b0, 1'b0, 1'b0, 1'b1);
            if (!vb) sv_d = 1'b1;
          end
        end
        fl_d[lsel] = nf;
        off_d      = o;
      end
    end else if (hit && dat_rd_i) begin
      if (cur == ST_DONE) begin
        for (int k = 0; k < 4; k++) begin
          if (3'(k) < sz && nf.data_av) begin
            rdata[8*k +: 8] = rd_word[8*k +: 8];
            o = o + 1'b1;
            if (o >= rsp_len) begin
              nf   = fl_set(nf, 1'b0, 1'b0, 1'b0, 1'b1);
              sv_d = 1'b1;
            end
          end
        end
        fl_d[lsel] = nf;
        off_d      = o;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NLOC; i++) begin
        st_q[i] <= ST_IDLE;
        fl_q[i] <= '0;
      end
      off_q         <= '0;
      abt_q         <= 1'b0;
      exl_q         <= '0;
      irq_cmd_rdy_o <= 1'b0;
      irq_sts_vld_o <= 1'b0;
      irq_data_av_o <= 1'b0;
      irq_loc_o     <= '0;
      be_go_o       <= 1'b0;
      be_len_o      <= '0;
      be_cancel_o   <= 1'b0;
    end else begin
      st_q          <= st_d;
      fl_q          <= fl_d;
      off_q         <= off_d;
      abt_q         <= abt_d;
      exl_q         <= exl_d;
      irq_cmd_rdy_o <= cr_d;
      irq_sts_vld_o <= sv_d;
      irq_data_av_o <= da_d;
      irq_loc_o     <= iloc_d;
      be_go_o       <= go_d;
      be_cancel_o   <= can_d;
      if (go_d) be_len_o <= off_q;
    end
  end

  assign dat_rdata_o = rdata;
  assign sts_o = loc_ok ? {FAMILY, 1'b0, fl_q[lsel].selftest, fl_q[lsel].cmd_rdy,
                           fl_q[lsel].expt, fl_q[lsel].data_av, fl_q[lsel].valid} : 8'h00;

  // R13
  off_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(off_q) <= DEPTH);

  // R5
  go_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_go_o |-> st_q[exl_q] == ST_EXEC);

  // R6
  da_irq_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_data_av_o |-> (st_q[irq_loc_o] == ST_DONE && fl_q[irq_loc_o].data_av && off_q == '0));

  // R10
  cancel_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_cancel_o |-> abt_q);

  for (genvar i = 0; i < NLOC; i++) begin : g_chk
    // R4
    expect_recv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fl_q[i].expt |-> st_q[i] == ST_RECV);
    // R7
    da_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fl_q[i].data_av |-> st_q[i] == ST_DONE);
  end

endmodule

// File: tb/cmd_rsp_xfer_tb_top.sv
`timescale 1ns/1ps
module cmd_rsp_xfer_tb_top;

  localparam int NLOC  = 5;
  localparam int DEPTH = 320;
  localparam int LW    = $clog2(NLOC);
  localparam int OW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          act_vld = 1'b0;
  logic [LW-1:0] act_loc = '0;
  logic [LW-1:0] loc = '0;
  logic          sts_wr = 1'b0;
  logic [2:0]    sts_val = '0;
  logic          dat_wr = 1'b0, dat_rd = 1'b0;
  logic [2:0]    dat_size = 3'd4;
  logic [31:0]   dat_wdata = '0;
  logic [31:0]   dat_rdata;
  logic          sts_rd_byte = 1'b0;
  logic [7:0]    sts;
  logic [OW-1:0] burst;
  logic          be_go, be_cancel;
  logic [OW-1:0] be_len;
  logic          be_we = 1'b0;
  logic [OW-1:0] be_idx = '0;
  logic [7:0]    be_byte = '0;
  logic          be_done = 1'b0, be_selftest = 1'b0;
  logic          irq_cr, irq_sv, irq_da;
  logic [LW-1:0] irq_loc;

  int n_run = 0, n_fail = 0;
  logic [31:0]   rd_c;
  logic          cr_c, sv_c, da_c, go_c, can_c;
  logic [OW-1:0] len_c;

  always #4 clk = ~clk;

  cmd_rsp_xfer #(.NLOC(NLOC), .DEPTH(DEPTH), .FAMILY(2'b01)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .act_vld_i(act_vld), .act_loc_i(act_loc), .loc_i(loc),
    .sts_wr_i(sts_wr), .sts_val_i(sts_val), .dat_wr_i(dat_wr), .dat_rd_i(dat_rd),
    .dat_size_i(dat_size), .dat_wdata_i(dat_wdata), .dat_rdata_o(dat_rdata),
    .sts_rd_byte_i(sts_rd_byte), .sts_o(sts), .burst_o(burst),
    .be_go_o(be_go), .be_len_o(be_len), .be_cancel_o(be_cancel),
    .be_we_i(be_we), .be_idx_i(be_idx), .be_byte_i(be_byte),
    .be_done_i(be_done), .be_selftest_i(be_selftest),
    .irq_cmd_rdy_o(irq_cr), .irq_sts_vld_o(irq_sv), .irq_data_av_o(irq_da), .irq_loc_o(irq_loc)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic grab();
    cr_c = irq_cr; sv_c = irq_sv; da_c = irq_da;
    go_c = be_go; len_c = be_len; can_c = be_cancel;
  endtask

  task automatic acc(input logic [LW-1:0] l, input logic sw, input logic [2:0] sv,
                     input logic dw, input logic dr, input logic [2:0] sz, input logic [31:0] wd);
    @(negedge clk);
    loc = l; sts_wr = sw; sts_val = sv; dat_wr = dw; dat_rd = dr; dat_size = sz; dat_wdata = wd;
    #1 rd_c = dat_rdata;
    @(posedge clk); #1;
    grab();
    sts_wr = 1'b0; dat_wr = 1'b0; dat_rd = 1'b0;
  endtask

  task automatic sw_cmd(input logic [2:0] v); acc(3'd0, 1'b1, v, 1'b0, 1'b0, 3'd4, 32'h0); endtask
  task automatic wr(input logic [2:0] sz, input logic [31:0] d); acc(3'd0, 1'b0, 3'd0, 1'b1, 1'b0, sz, d); endtask
  task automatic rd(input logic [2:0] sz); acc(3'd0, 1'b0, 3'd0, 1'b0, 1'b1, sz, 32'h0); endtask

  task automatic peek(input logic [LW-1:0] l);
    @(negedge clk); loc = l; #1;
  endtask

  task automatic be_put(input int idx, input logic [7:0] b);
    @(negedge clk); be_we = 1'b1; be_idx = OW'(idx); be_byte = b;
    @(posedge clk); #1 be_we = 1'b0;
  endtask

  task automatic be_finish(input logic st);
    @(negedge clk); be_done = 1'b1; be_selftest = st;
    @(posedge clk); #1; grab();
    be_done = 1'b0; be_selftest = 1'b0;
  endtask

  task automatic t_reset();
    peek(3'd0);
    chk("R1", "sts after reset", sts, 8'h40);
    chk("R1", "burst after reset", burst, DEPTH);
    peek(3'd1);
    chk("R1", "sts loc1 after reset", sts, 8'h40);
    chk("R11", "burst inactive loc", burst, 0);
  endtask

  task automatic t_idle_and_arm();
    wr(3'd4, 32'h11223344);
    chk("R3", "idle write dropped sts", sts, 8'h40);
    chk("R3", "idle write dropped burst", burst, DEPTH);
    sw_cmd(3'b011);
    chk("R2", "bad combo no irq", cr_c, 0);
    chk("R2", "bad combo sts", sts, 8'h40);
    sw_cmd(3'b001);
    chk("R2", "cmd-ready irq", cr_c, 1);
    chk("R2", "ready sts", sts, 8'h48);
    sw_cmd(3'b001);
    chk("R2", "cmd-ready in ready no irq", cr_c, 0);
    chk("R2", "ready sts kept", sts, 8'h48);
    rd(3'd4);
    chk("R7", "read outside completion", rd_c, 32'hFFFF_FFFF);
  endtask

  task automatic t_command();
    wr(3'd4, 32'h0000_0180);
    chk("R3", "reception sts", sts, 8'h45);
    chk("R11", "free space", burst, DEPTH - 4);
    sw_cmd(3'b010);
    chk("R5", "go with expect ignored", go_c, 0);
    wr(3'd4, 32'h2211_0A00);
    chk("R4", "expect held len 10 off 8", sts, 8'h45);
    chk("R4", "no sts-valid irq", sv_c, 0);
    wr(3'd2, 32'h0000_4433);
    chk("R4", "packet complete", sts, 8'h41);
    chk("R11", "free after 10", burst, DEPTH - 10);
    sw_cmd(3'b010);
    chk("R5", "go pulse", go_c, 1);
    chk("R5", "go length", len_c, 10);
    wr(3'd4, 32'hDEAD_BEEF);
    chk("R3", "exec write dropped", burst, DEPTH - 10);
  endtask

  task automatic t_response();
    logic [7:0] rsp [7] = '{8'hC4, 8'h00, 8'h00, 8'h00, 8'h00, 8'h07, 8'hAB};
    for (int i = 0; i < 7; i++) be_put(i, rsp[i]);
    be_finish(1'b0);
    chk("R6", "data-av irq", da_c, 1);
    chk("R6", "sts-valid irq", sv_c, 1);
    chk("R6", "completion sts", sts, 8'h43);
    chk("R11", "remaining bytes", burst, 7);
    rd(3'd4);
    chk("R7", "first word", rd_c, 32'h0000_00C4);
    chk("R11", "remaining after 4", burst, 3);
    rd(3'd4);
    chk("R7", "tail word", rd_c, 32'hFFAB_0700);
    chk("R7", "last byte irq", sv_c, 1);
    chk("R7", "valid only", sts, 8'h41);
    rd(3'd1);
    chk("R7", "read after drain", rd_c, 32'hFFFF_FFFF);
    sw_cmd(3'b100);
    chk("R8", "retry sts", sts, 8'h43);
    chk("R8", "retry burst", burst, 7);
    rd(3'd1);
    chk("R8", "retry first byte", rd_c, 32'hFFFF_FFC4);
    sw_cmd(3'b001);
    chk("R9", "completion cmd-ready irq", cr_c, 1);
    chk("R9", "completion to ready sts", sts, 8'h48);
    chk("R9", "offset zeroed", burst, DEPTH);
    @(negedge clk); sts_rd_byte = 1'b1; #1;
    chk("R11", "byte status clamp", burst, 255);
    sts_rd_byte = 1'b0;
  endtask

  task automatic t_aborts();
    wr(3'd4, 32'h0000_0180);
    sw_cmd(3'b001);
    chk("R10", "reception abort irq", cr_c, 1);
    chk("R10", "reception abort sts", sts, 8'h48);
    chk("R10", "reception abort offset", burst, DEPTH);
    wr(3'd4, 32'h0000_0180);
    wr(3'd2, 32'h0000_0600);
    chk("R4", "six byte packet complete", sts, 8'h41);
    sw_cmd(3'b010);
    chk("R5", "go length 6", len_c, 6);
    sw_cmd(3'b001);
    chk("R10", "cancel pulse", can_c, 1);
    chk("R10", "no irq yet", cr_c, 0);
    be_finish(1'b1);
    chk("R10", "abort completion irq", cr_c, 1);
    chk("R10", "no data-av irq", da_c, 0);
    chk("R12", "selftest kept with cmd-ready", sts, 8'h58);
    peek(3'd1);
    chk("R12", "selftest on other loc", sts, 8'h50);
  endtask

  task automatic t_inactive();
    acc(3'd1, 1'b1, 3'b001, 1'b0, 1'b0, 3'd4, 32'h0);
    chk("R12", "inactive cmd-ready irq", cr_c, 0);
    chk("R12", "inactive sts", sts, 8'h50);
    acc(3'd1, 1'b0, 3'd0, 1'b1, 1'b0, 3'd4, 32'h0000_0180);
    peek(3'd0);
    chk("R12", "inactive write ignored", burst, DEPTH);
    chk("R12", "active sts unchanged", sts, 8'h58);
  endtask

  task automatic t_overflow();
    wr(3'd4, 32'h0000_0180);
    wr(3'd4, 32'h0000_0002);
    for (int i = 2; i < DEPTH / 4; i++) wr(3'd4, 32'h5555_5555);
    chk("R13", "full still expecting", sts, 8'h55);
    chk("R13", "no free space", burst, 0);
    wr(3'd4, 32'h6666_6666);
    chk("R13", "overflow clears expect", sts, 8'h51);
    chk("R13", "offset capped", burst, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; act_vld = 1'b1; act_loc = '0;
    t_reset();
    t_idle_and_arm();
    t_command();
    t_response();
    t_aborts();
    t_inactive();
    t_overflow();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule